// File: doc/BRIEF.md
# Pixel To Bus Cycle Packer

This block sits between a pixel source and the strobe timer of a parallel display bus. It takes pixels of 12, 16, 18 or 24 bits from a valid/ready stream. It cuts each pixel into bus words for a data bus 8, 9, 12 or 16 lines wide. The most significant part always goes out first. A cycle-format setting picks one, two or three bus words per pixel, or a packed mode that spreads two pixels over three words.

A frame begins with a one-cycle `start` pulse. The pulse captures the data type, bus width, cycle format and pixel total, and the block stays busy until that many pixels have left as bus words. When the last word has been taken downstream, the block drops busy and gives a single-cycle frame-done pulse. A setting whose pixel width does not fit the bus width under the chosen cycle format is refused. A zero pixel total is refused as well. In both cases an error flag is raised and no pixel is taken.

Top module: `pkp_packer`

## Requirements
- R1: The data type codes are 0=12, 1=16, 2=18 and 3=24 bits per pixel. The bus mode codes are 0=8, 1=9, 2=12 and 3=16 lines. The cycle format codes are 0=one word per pixel, 1=two words, 2=three words and 3=three words per two pixels. A combination is accepted only when the pixel width equals the bus width times the words per pixel, or, for code 3, when twice the pixel width equals three bus widths.
- R2: In formats 0 to 2, each pixel goes out as L-bit pieces, most significant first. For example, 16 bits on 8 lines sends bits 15:8 and then 7:0, and 24 bits on 8 lines sends 23:16, 15:8 and 7:0. The piece sits in bus_data[L-1:0], and every bus_data bit at position L or above is 0.
- R3: In format 3, with h = L/2 and pixels A and B taken in that order, the words are: A's upper L bits; then A's lower h bits above B's upper h bits; then B's lower L bits.
- R4: In format 3 with an odd pixel total, the final pixel goes out as two words. The second of these carries its lower h bits in the upper half, and the lower half is zero.
- R5: Pixel input bits at or above the selected pixel width have no effect on any bus word.
- R6: A start pulse while idle captures the settings and the total and raises busy on the next cycle. Later changes to the settings inputs, and any start pulse while busy, do not affect the frame in progress.
- R7: Exactly the programmed number of pixels is accepted. frame_done is high for exactly one cycle, the cycle after the last word is accepted, and busy is low in that same cycle.
- R8: A refused combination, or a total of zero, sets cfg_err and leaves busy, pix_ready and bus_valid low. The next accepted start clears cfg_err.
- R9: While bus_valid is high and bus_ready is low, bus_valid stays high and bus_data does not change. pix_ready is never high while a word is being offered.
- R10: After reset, busy, cfg_err, frame_done, pix_ready and bus_valid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle frame start request |
| pix_total | input | CNT_W | Number of pixels in the frame |
| data_type | input | 2 | Pixel width code |
| bus_mode | input | 2 | Bus width code |
| cycle_fmt | input | 2 | Words-per-pixel code |
| pix_valid | input | 1 | Pixel offered |
| pix_data | input | 24 | Pixel value, right aligned |
| pix_ready | output | 1 | Pixel accepted this cycle when valid |
| bus_valid | output | 1 | Bus word offered |
| bus_data | output | 16 | Bus word, right aligned |
| bus_dsel | output | 1 | Data-select flag (high for pixel data words) |
| bus_ready | input | 1 | Strobe timer takes the word |
| busy | output | 1 | Frame in progress |
| cfg_err | output | 1 | Last start was refused |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench builds the packer with CNT_W set to 8. Frames stay short, at most a dozen pixels, so every accepted width/format pairing can be run many times within the cycle budget. The odd and even totals of the packed format, single-pixel frames and the zero-total refusal are all within reach. Random back-pressure on both handshakes reaches the cases where a word is held, or a pixel waits, across several cycles.

// File: rtl/pkp_pkg.sv
package pkp_pkg;
    localparam int PIX_W = 24;
    localparam int BUS_W = 16;

    typedef enum logic [1:0] {
        FMT_ONE   = 2'd0,
        FMT_TWO   = 2'd1,
        FMT_THREE = 2'd2,
        FMT_PAIR  = 2'd3
    } cyc_fmt_e;

    function automatic logic [4:0] width_of_type(input logic [1:0] code);
        case (code)
            2'd0:    return 5'd12;
            2'd1:    return 5'd16;
            2'd2:    return 5'd18;
            default: return 5'd24;
        endcase
    endfunction

    function automatic logic [4:0] lines_of_mode(input logic [1:0] code);
        case (code)
            2'd0:    return 5'd8;
            2'd1:    return 5'd9;
            2'd2:    return 5'd12;
            default: return 5'd16;
        endcase
    endfunction
endpackage

// File: rtl/pkp_fmt_check.sv
module pkp_fmt_check
    import pkp_pkg::*;
(
    input  logic [1:0] data_type,
    input  logic [1:0] bus_mode,
    input  logic [1:0] cycle_fmt,
    output logic       fmt_ok,
    output logic [4:0] lines
);
    logic [6:0] bpp;
    logic [6:0] ln;

    always_comb begin
        bpp   = {2'b00, width_of_type(data_type)};
        ln    = {2'b00, lines_of_mode(bus_mode)};
        lines = ln[4:0];
        // R1: width must match bus width times words per pixel
        case (cyc_fmt_e'(cycle_fmt))
            FMT_ONE:   fmt_ok = (bpp == ln);
            FMT_TWO:   fmt_ok = (bpp == 7'(2 * ln));
            FMT_THREE: fmt_ok = (bpp == 7'(3 * ln));
            default:   fmt_ok = (7'(2 * bpp) == 7'(3 * ln));
        endcase
    end
endmodule

// File: rtl/pkp_slicer.sv
module pkp_slicer
    import pkp_pkg::*;
(
    input  logic [PIX_W-1:0] pix_a,
    input  logic [PIX_W-1:0] pix_b,
    input  logic [4:0]       lines,
    input  logic [1:0]       cycle_fmt,
    input  logic [1:0]       phase,
    input  logic [1:0]       nwords,
    output logic [BUS_W-1:0] word
);
    logic [31:0] a32, b32, mask_l, mask_h, w32;
    logic [4:0]  half;
    logic [1:0]  rank;
    logic [5:0]  sh;

    always_comb begin
        a32    = {8'd0, pix_a};
        b32    = {8'd0, pix_b};
        half   = lines >> 1;
        mask_l = (32'd1 << lines) - 32'd1;
        mask_h = (32'd1 << half) - 32'd1;
        rank   = nwords - 2'd1 - phase;
        sh     = {4'd0, rank} * {1'b0, lines};
        if (cyc_fmt_e'(cycle_fmt) == FMT_PAIR) begin
            // R3: two pixels over three words, half-width pieces in the middle
            case (phase)
                2'd0:    w32 = (a32 >> half) & mask_l;
                2'd1:    w32 = ((a32 & mask_h) << half) | ((b32 >> lines) & mask_h);
                default: w32 = b32 & mask_l;
            endcase
        end else begin
            // R2: most significant piece first
            w32 = (a32 >> sh) & mask_l;
        end
        word = w32[BUS_W-1:0];
    end
endmodule

// File: rtl/pkp_packer.sv
module pkp_packer
    import pkp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] pix_total,
    input  logic [1:0]       data_type,
    input  logic [1:0]       bus_mode,
    input  logic [1:0]       cycle_fmt,
    input  logic             pix_valid,
    input  logic [PIX_W-1:0] pix_data,
    output logic             pix_ready,
    output logic             bus_valid,
    output logic [BUS_W-1:0] bus_data,
    output logic             bus_dsel,
    input  logic             bus_ready,
    output logic             busy,
    output logic             cfg_err,
    output logic             frame_done
);
    typedef struct packed {
        logic             busy;
        logic             err;
        logic             done;
        logic [CNT_W-1:0] rem;
        logic [1:0]       dt;
        logic [1:0]       pm;
        logic [1:0]       cf;
        logic [1:0]       held;
        logic [1:0]       phase;
        logic [PIX_W-1:0] pa;
        logic [PIX_W-1:0] pb;
    } state_t;

    state_t st_q, st_d;

    logic [1:0] sel_dt, sel_pm, sel_cf;
    logic       fmt_ok;
    logic [4:0] lines;
    logic [1:0] need, nwords;
    logic       gather, offer, last_word;

    assign sel_dt = st_q.busy ? st_q.dt : data_type;
    assign sel_pm = st_q.busy ? st_q.pm : bus_mode;
    assign sel_cf = st_q.busy ? st_q.cf : cycle_fmt;

    pkp_fmt_check u_check (
        .data_type (sel_dt),
        .bus_mode  (sel_pm),
        .cycle_fmt (sel_cf),
        .fmt_ok    (fmt_ok),
        .lines     (lines)
    );

    always_comb begin
        need   = (cyc_fmt_e'(st_q.cf) == FMT_PAIR && st_q.rem >= CNT_W'(2)) ? 2'd2 : 2'd1;
        case (cyc_fmt_e'(st_q.cf))
            FMT_ONE:   nwords = 2'd1;
            FMT_TWO:   nwords = 2'd2;
            FMT_THREE: nwords = 2'd3;
            default:   nwords = (need == 2'd2) ? 2'd3 : 2'd2; // R4
        endcase
        gather    = st_q.busy && (st_q.held < need);
        offer     = st_q.busy && (st_q.held == need);
        last_word = (st_q.phase == nwords - 2'd1);
    end

    pkp_slicer u_slice (
        .pix_a     (st_q.pa),
        .pix_b     (st_q.pb),
        .lines     (lines),
        .cycle_fmt (st_q.cf),
        .phase     (st_q.phase),
        .nwords    (nwords),
        .word      (bus_data)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start && !st_q.busy) begin
            // R6 / R8: capture settings, refuse bad ones
            st_d.err   = !fmt_ok || (pix_total == '0);
            st_d.busy  = fmt_ok && (pix_total != '0);
            st_d.rem   = pix_total;
            st_d.dt    = data_type;
            st_d.pm    = bus_mode;
            st_d.cf    = cycle_fmt;
            st_d.held  = 2'd0;
            st_d.phase = 2'd0;
        end else if (st_q.busy) begin
            if (gather && pix_valid) begin
                if (st_q.held == 2'd0) begin
                    st_d.pa = pix_data;
                    st_d.pb = '0;
                end else begin
                    st_d.pb = pix_data;
                end
                st_d.held = st_q.held + 2'd1;
            end
            if (offer && bus_ready) begin
                if (last_word) begin
                    st_d.phase = 2'd0;
                    st_d.held  = 2'd0;
                    st_d.rem   = st_q.rem - CNT_W'(need);
                    if (st_q.rem == CNT_W'(need)) begin
                        st_d.busy = 1'b0;
                        st_d.done = 1'b1; // R7
                    end
                end else begin
                    st_d.phase = st_q.phase + 2'd1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0; // R10
        end else begin
            st_q <= st_d;
        end
    end

    assign pix_ready  = gather;
    assign bus_valid  = offer;
    assign bus_dsel   = offer;
    assign busy       = st_q.busy;
    assign cfg_err    = st_q.err;
    assign frame_done = st_q.done;

    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_data)); // R9
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(pix_ready && bus_valid)); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !busy && !bus_valid); // R7
    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !busy && !pix_ready && !bus_valid); // R8
    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)); // R6
endmodule

// File: tb/pkp_packer_test.sv
module pkp_packer_test;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [CNT_W-1:0] pix_total = '0;
    logic [1:0]       data_type = '0, bus_mode = '0, cycle_fmt = '0;
    logic             pix_valid = 1'b0;
    logic [23:0]      pix_data = '0;
    logic             pix_ready, bus_valid, bus_dsel, busy, cfg_err, frame_done;
    logic [15:0]      bus_data;
    logic             bus_ready = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit finished = 0;

    logic [23:0] pix_arr [0:15];
    logic [15:0] exp_w   [0:63];
    int          n_exp;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkp_packer #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .pix_total(pix_total),
        .data_type(data_type), .bus_mode(bus_mode), .cycle_fmt(cycle_fmt),
        .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
        .bus_valid(bus_valid), .bus_data(bus_data), .bus_dsel(bus_dsel),
        .bus_ready(bus_ready), .busy(busy), .cfg_err(cfg_err),
        .frame_done(frame_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int bpp_of(input logic [1:0] t);
        case (t) 2'd0: return 12; 2'd1: return 16; 2'd2: return 18; default: return 24; endcase
    endfunction

    function automatic int lines_of(input logic [1:0] m);
        case (m) 2'd0: return 8; 2'd1: return 9; 2'd2: return 12; default: return 16; endcase
    endfunction

    function automatic bit combo_ok(input logic [1:0] t, input logic [1:0] m, input logic [1:0] f);
        int b = bpp_of(t);
        int l = lines_of(m);
        case (f)
            2'd0: return b == l;
            2'd1: return b == 2*l;
            2'd2: return b == 3*l;
            default: return 2*b == 3*l;
        endcase
    endfunction

    // Bit-stream model: all pixels MSB first, cut into L-bit words, zero padded
    task automatic build_exp(input logic [1:0] t, input logic [1:0] m, input int n);
        logic stream [0:511];
        int b = bpp_of(t);
        int l = lines_of(m);
        int pos = 0;
        for (int i = 0; i < 512; i++) stream[i] = 1'b0;
        for (int p = 0; p < n; p++)
            for (int k = b - 1; k >= 0; k--) begin
                stream[pos] = pix_arr[p][k];
                pos++;
            end
        n_exp = (pos + l - 1) / l;
        for (int w = 0; w < n_exp; w++) begin
            exp_w[w] = '0;
            for (int j = 0; j < l; j++) exp_w[w][l-1-j] = stream[w*l + j];
        end
    endtask

    task automatic run_frame(input logic [1:0] t, input logic [1:0] m, input logic [1:0] f,
                             input int n, input bit disturb);
        int  pi = 0;
        int  wi = 0;
        bit  last_seen = 0;
        bit  ended = 0;
        build_exp(t, m, n);
        @(negedge clk);
        data_type = t; bus_mode = m; cycle_fmt = f; pix_total = CNT_W'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R6 busy after start", busy, 1);
        chk(cfg_err == 1'b0, "R8 err cleared by good start", cfg_err, 0);
        for (int cyc = 0; cyc < 3000; cyc++) begin
            if (last_seen) begin
                chk(frame_done == 1'b1, "R7 done after last word", frame_done, 1);
                chk(busy == 1'b0, "R7 busy low with done", busy, 0);
                ended = 1;
                break;
            end
            chk(frame_done == 1'b0, "R7 no early done", frame_done, 0);
            if (disturb && cyc == 2) begin
                data_type = ~t; bus_mode = ~m; cycle_fmt = f + 2'd1;
                pix_total = CNT_W'(1); start = 1'b1;
            end else begin
                start = 1'b0;
            end
            pix_valid = (pi < n) && ($urandom % 4 != 0);
            pix_data  = (pi < n) ? pix_arr[pi] : 24'hABCDEF;
            bus_ready = ($urandom % 3 != 0);
            #1;
            if (pix_valid && pix_ready) pi++;
            if (bus_valid && bus_ready) begin
                if (wi < n_exp)
                    chk(bus_data == exp_w[wi], (f == 2'd3) ? "R3 packed word" : "R2 word", bus_data, exp_w[wi]);
                else
                    chk(1'b0, "R7 extra word", wi, n_exp);
                wi++;
                if (wi == n_exp) last_seen = 1;
            end
            @(negedge clk);
        end
        start = 1'b0; pix_valid = 1'b0; bus_ready = 1'b0;
        chk(ended, "R7 frame ended", ended, 1);
        chk(pi == n, "R7 pixels consumed", pi, n);
        chk(wi == n_exp, "R7 words emitted", wi, n_exp);
        @(negedge clk);
        chk(frame_done == 1'b0, "R7 done one cycle", frame_done, 0);
    endtask

    task automatic run_refused(input logic [1:0] t, input logic [1:0] m, input logic [1:0] f, input int n);
        @(negedge clk);
        data_type = t; bus_mode = m; cycle_fmt = f; pix_total = CNT_W'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        pix_valid = 1'b1; pix_data = 24'h123456; bus_ready = 1'b1;
        chk(cfg_err == 1'b1, "R8 err set", cfg_err, 1);
        for (int c = 0; c < 8; c++) begin
            #1;
            chk(!pix_ready && !bus_valid && !busy, "R8 nothing taken",
                {pix_ready, bus_valid, busy}, 0);
            @(negedge clk);
        end
        pix_valid = 1'b0; bus_ready = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !finished) begin
            finished = 1;
            n_fails++;
            $display("FAIL watchdog actual=%0d expected=<190000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        chk({busy, cfg_err, frame_done, pix_ready, bus_valid} == 5'b0, "R10 reset state",
            {busy, cfg_err, frame_done, pix_ready, bus_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, cfg_err, frame_done, pix_ready, bus_valid} == 5'b0, "R10 after reset",
            {busy, cfg_err, frame_done, pix_ready, bus_valid}, 0);

        // Directed: every accepted combination (R1), odd totals for the packed mode (R4)
        for (int t = 0; t < 4; t++)
            for (int m = 0; m < 4; m++)
                for (int f = 0; f < 4; f++)
                    if (combo_ok(2'(t), 2'(m), 2'(f))) begin
                        for (int p = 0; p < 16; p++) pix_arr[p] = $urandom;
                        run_frame(2'(t), 2'(m), 2'(f), 5, 0);
                        for (int p = 0; p < 16; p++) pix_arr[p] = 24'hFFFFFF; // R5 junk in upper bits
                        run_frame(2'(t), 2'(m), 2'(f), 1, 0);
                    end

        // R5: upper-bit junk vs clean pixel give identical words, 12 bpp on 12 lines
        pix_arr[0] = 24'hF00ABC; pix_arr[1] = 24'h000123;
        run_frame(2'd0, 2'd2, 2'd0, 2, 0);
        chk(exp_w[0] == 16'h0ABC, "R5 model sanity", exp_w[0], 16'h0ABC);

        // R4 directed: 12 bpp on 8 lines, one pixel -> AB, C0
        pix_arr[0] = 24'h000ABC;
        run_frame(2'd0, 2'd0, 2'd3, 1, 0);
        chk(n_exp == 2 && exp_w[1] == 16'h00C0, "R4 tail model", exp_w[1], 16'h00C0);

        // R6: settings change and start pulse mid-frame
        for (int p = 0; p < 16; p++) pix_arr[p] = $urandom;
        run_frame(2'd3, 2'd0, 2'd2, 6, 1);
        run_frame(2'd0, 2'd0, 2'd3, 7, 1);

        // R8: refused combos and zero total
        run_refused(2'd1, 2'd1, 2'd0, 4);
        run_refused(2'd3, 2'd3, 2'd0, 4);
        run_refused(2'd1, 2'd0, 2'd1, 0);
        for (int p = 0; p < 16; p++) pix_arr[p] = $urandom;
        run_frame(2'd1, 2'd0, 2'd1, 3, 0);

        // Random frames over accepted combinations
        for (int r = 0; r < 40; r++) begin
            logic [1:0] t, m, f;
            do begin
                t = 2'($urandom); m = 2'($urandom); f = 2'($urandom);
            end while (!combo_ok(t, m, f));
            for (int p = 0; p < 16; p++) pix_arr[p] = $urandom;
            run_frame(t, m, f, 1 + ($urandom % 12), (r % 5) == 0);
        end

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule